// File: doc/BRIEF.md
# Multi-Format Serial PCM Receive Port

This block takes stereo PCM from a three-wire serial link (bit clock, data, frame sync) and turns it into parallel words for a transmit stage. A 3-bit mode input chooses the framing. In one mode the port is the timing master: it makes the bit clock and frame sync itself from the system clock. In the other modes it follows a bit clock and frame sync supplied from outside. All of its logic runs on the system clock, and the serial lines are sampled as plain levels.

Each word is shifted into a capture register. Words may be 16 to 24 bits long. The frame-sync edge that closes a word copies it into a holding register, left-aligned to the output width with zeros below it. The holding register also receives the channel tag and the channel-status, user and validity side bits, which are sampled at a bit position that depends on the format. The transmit side reads only the holding register, and a one-cycle strobe tells it that a new word has arrived.

Top module: `pcm_serial_rx`

## Requirements
- R1: In mode 0 the port drives `sck_out` with a period of 2*SCK_HALF system clocks. It toggles `fs_out` only at a falling edge of `sck_out`, after every 32 bit clocks. `port_drive` is high in this mode only. Words are MSB-first, with the MSB in the first bit after each `fs_out` change, and `fs_out` high marks left.
- R2: In the input modes, data and frame sync are sampled at the rising bit-clock edge. In mode 1 each frame-sync change starts a word with its MSB in that same bit, and a high level marks left. A word shorter than 24 bits, sent with trailing zeros or with fewer clocks, appears left-aligned with zero low bits. `word_right` is 0 for left and 1 for right.
- R3: In mode 2 a rising edge of the word-sync line starts a word with its MSB in that bit, and the falling edge is ignored. The channel tags alternate, and the first word after reset is left.
- R4: In mode 4 the MSB arrives one bit after each frame-sync change, and a low level marks left.
- R5: Modes 5 and 6 take the last 16 or 18 bits before a frame-sync change, with the LSB last. Any earlier bits are ignored, and the output's low 8 or 6 bits are zero.
- R6: In mode 7 the LSB is sent first and the MSB falls in the last bit before the frame-sync change. Short words, led by zeros or sent with fewer clocks, appear left-aligned.
- R7: The side bits are sampled in bit 0 of a word (bit 1 in mode 4) and are delivered with that word on `side_out` as {channel status, user, validity} in bits [2:0].
- R8: A word reaches the outputs at the frame-sync edge that ends it, and `word_valid` pulses for one cycle. The outputs stay unchanged between pulses. The first edge after reset delivers nothing.
- R9: Mode 3 is reserved and never raises `word_valid`.
- R10: During reset and just after it, `word_out`, `word_right`, `side_out`, `word_valid`, `sck_out` and `fs_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, fast enough to oversample the bit clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 3 | Framing select, 0 to 7 |
| sck_in | input | 1 | External bit clock (modes 1 to 7) |
| fs_in | input | 1 | External frame or word sync (modes 1 to 7) |
| sd_in | input | 1 | Serial audio data |
| c_in | input | 1 | Serial channel-status bit |
| u_in | input | 1 | Serial user bit |
| v_in | input | 1 | Serial validity bit |
| sck_out | output | 1 | Generated bit clock (mode 0) |
| fs_out | output | 1 | Generated frame sync (mode 0) |
| port_drive | output | 1 | High when the generated clock and sync should drive the link |
| word_out | output | WORD_W | Held word, left-aligned |
| word_right | output | 1 | Channel tag of the held word |
| side_out | output | 3 | Side bits held with the word |
| word_valid | output | 1 | One-cycle strobe on a new held word |

## Verification
The assertions assume that `mode` stays constant between resets. They also assume that the bit clock stays high and low for at least one system clock each, and that data and frame sync change only near the falling bit-clock edge. The bench resets the block before every mode change. It drives `sck_in`, `fs_in`, `sd_in` and the side bits on falling system-clock edges, with a bit-clock half period of four system clocks, and changes data only while it lowers the bit clock. In mode 2 the word-sync pulse is two bits wide, so the falling edge stays one bit period away from the rising edge.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

   typedef enum logic [2:0] {
      FMT_MASTER  = 3'd0,
      FMT_LJ      = 3'd1,
      FMT_WSYNC   = 3'd2,
      FMT_RSVD    = 3'd3,
      FMT_I2S     = 3'd4,
      FMT_RJ16    = 3'd5,
      FMT_RJ18    = 3'd6,
      FMT_MSBLAST = 3'd7
   } fmt_e;

   typedef struct packed {
      logic c;
      logic u;
      logic v;
   } side_t;

   // Bit index, counted from the word-start edge, at which side bits are taken
   function automatic int side_slot(fmt_e f);
      return (f == FMT_I2S) ? 1 : 0;
   endfunction

endpackage

// File: rtl/pcm_rx_clkgen.sv
module pcm_rx_clkgen #(
   parameter int SCK_HALF = 4,
   parameter int SLOTS    = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic sck_o,
   output logic fs_o
);
   localparam int DIV_W  = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
   localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

   logic [DIV_W-1:0]  div_q;
   logic [SLOT_W-1:0] slot_q;
   logic              sck_q;
   logic              fs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         slot_q <= '0;
         sck_q  <= 1'b0;
         fs_q   <= 1'b0;
      end else if (!en) begin
         div_q  <= '0;
         slot_q <= '0;
         sck_q  <= 1'b0;
         fs_q   <= 1'b0;
      end else if (div_q == DIV_W'(SCK_HALF - 1)) begin
         div_q <= '0;
         sck_q <= ~sck_q;
         if (sck_q) begin
            if (slot_q == SLOT_W'(SLOTS - 1)) begin
               slot_q <= '0;
               fs_q   <= ~fs_q;
            end else begin
               slot_q <= slot_q + 1'b1;
            end
         end
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   assign sck_o = sck_q;
   assign fs_o  = fs_q;

   // R1: the generated sync only moves together with a falling bit clock
   a_r1_fs_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && !$stable(fs_q)) |-> $fell(sck_q));

endmodule

// File: rtl/pcm_rx_framer.sv
module pcm_rx_framer
   import pcm_rx_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  fmt_e             fmt,
   input  logic             sck_i,
   input  logic             fs_i,
   input  side_t            side_i,
   output logic             bit_stb,
   output logic             word_start,
   output logic [CNT_W-1:0] cur_idx,
   output logic             ended_right,
   output logic             armed,
   output side_t            side_cap
);
   logic             sck_q, fs_prev_q, seen_q, armed_q, cur_right_q, ws_left_q;
   logic [CNT_W-1:0] cnt_q;
   side_t            side_q;
   logic             lr_mode, edge_raw, new_left;
   logic [CNT_W-1:0] side_pos;

   assign bit_stb    = sck_i & ~sck_q;
   assign lr_mode    = (fmt != FMT_WSYNC);
   assign edge_raw   = seen_q && (lr_mode ? (fs_i != fs_prev_q) : (fs_i & ~fs_prev_q));
   assign word_start = bit_stb && edge_raw && (fmt != FMT_RSVD);
   assign cur_idx    = word_start ? '0 : cnt_q;
   assign new_left   = lr_mode ? ((fmt == FMT_I2S) ? ~fs_i : fs_i) : ws_left_q;
   assign side_pos   = CNT_W'(side_slot(fmt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q       <= 1'b0;
         fs_prev_q   <= 1'b0;
         seen_q      <= 1'b0;
         armed_q     <= 1'b0;
         cur_right_q <= 1'b0;
         ws_left_q   <= 1'b1;
         cnt_q       <= '0;
         side_q      <= '0;
      end else begin
         sck_q <= sck_i;
         if (bit_stb) begin
            fs_prev_q <= fs_i;
            seen_q    <= 1'b1;
            if (word_start) begin
               cnt_q       <= CNT_W'(1);
               armed_q     <= 1'b1;
               cur_right_q <= ~new_left;
               if (!lr_mode) ws_left_q <= ~ws_left_q;
            end else if (cnt_q != '1) begin
               cnt_q <= cnt_q + 1'b1;
            end
            if (cur_idx == side_pos) side_q <= side_i;
         end
      end
   end

   assign ended_right = cur_right_q;
   assign armed       = armed_q;
   assign side_cap    = side_q;

   // R2: the bit counter sticks at its ceiling on long slots instead of wrapping
   a_r2_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && !word_start && cnt_q == '1) |=> (cnt_q == '1));

endmodule

// File: rtl/pcm_rx_shifter.sv
module pcm_rx_shifter
   import pcm_rx_pkg::*;
#(
   parameter int WORD_W = 24,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fmt_e              fmt,
   input  logic              bit_stb,
   input  logic              word_start,
   input  logic [CNT_W-1:0]  cur_idx,
   input  logic              sd,
   output logic [WORD_W-1:0] word_asm
);
   logic [WORD_W-1:0] sr_q, sr_d, base;
   logic [CNT_W-1:0]  off, di;

   always_comb begin
      unique case (fmt)
         FMT_RJ16: word_asm = {sr_q[15:0], {(WORD_W-16){1'b0}}};
         FMT_RJ18: word_asm = {sr_q[17:0], {(WORD_W-18){1'b0}}};
         default:  word_asm = sr_q;
      endcase
   end

   assign base = word_start ? '0 : sr_q;
   assign off  = (fmt == FMT_I2S) ? CNT_W'(1) : '0;
   assign di   = cur_idx - off;

   always_comb begin
      sr_d = sr_q;
      if (bit_stb) begin
         unique case (fmt)
            FMT_RJ16, FMT_RJ18: sr_d = {sr_q[WORD_W-2:0], sd};
            FMT_MSBLAST:        sr_d = {sd, base[WORD_W-1:1]};
            FMT_RSVD:           sr_d = sr_q;
            default: begin
               sr_d = base;
               if (cur_idx >= off) begin
                  for (int i = 0; i < WORD_W; i++) begin
                     if (32'(di) == WORD_W - 1 - i) sr_d[i] = sd;
                  end
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= sr_d;
   end

endmodule

// File: rtl/pcm_rx_hold.sv
module pcm_rx_hold
   import pcm_rx_pkg::*;
#(
   parameter int WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word_in,
   input  logic              right_in,
   input  side_t             side_in,
   output logic [WORD_W-1:0] word_q,
   output logic              right_q,
   output side_t             side_q,
   output logic              valid_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q  <= '0;
         right_q <= 1'b0;
         side_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= load;
         if (load) begin
            word_q  <= word_in;
            right_q <= right_in;
            side_q  <= side_in;
         end
      end
   end
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
   import pcm_rx_pkg::*;
#(
   parameter int WORD_W     = 24,
   parameter int SCK_HALF   = 4,
   parameter int SLOTS      = 32,
   parameter int MAX_SLOT   = 63,
   parameter int HAS_MASTER = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode,
   input  logic              sck_in,
   input  logic              fs_in,
   input  logic              sd_in,
   input  logic              c_in,
   input  logic              u_in,
   input  logic              v_in,
   output logic              sck_out,
   output logic              fs_out,
   output logic              port_drive,
   output logic [WORD_W-1:0] word_out,
   output logic              word_right,
   output logic [2:0]        side_out,
   output logic              word_valid
);
   localparam int CNT_W = $clog2(MAX_SLOT + 1);

   if (WORD_W < 18 || WORD_W > 32) begin : g_bad_width
      $error("pcm_serial_rx: WORD_W must lie in 18..32");
   end
   if (SCK_HALF < 2) begin : g_bad_half
      $error("pcm_serial_rx: SCK_HALF must be at least 2");
   end
   if (SLOTS < WORD_W + 1 || SLOTS > MAX_SLOT) begin : g_bad_slots
      $error("pcm_serial_rx: SLOTS must exceed WORD_W and fit MAX_SLOT");
   end

   fmt_e              fmt;
   logic              gen_sck, gen_fs, sck_i, fs_i;
   logic              bit_stb, word_start, ended_right, armed;
   logic [CNT_W-1:0]  cur_idx;
   side_t             side_cap, side_held;
   logic [WORD_W-1:0] word_asm;

   assign fmt = fmt_e'(mode);

   if (HAS_MASTER != 0) begin : g_master
      pcm_rx_clkgen #(.SCK_HALF(SCK_HALF), .SLOTS(SLOTS)) u_gen (
         .clk  (clk),
         .rst_n(rst_n),
         .en   (fmt == FMT_MASTER),
         .sck_o(gen_sck),
         .fs_o (gen_fs)
      );
      assign port_drive = (fmt == FMT_MASTER);
   end else begin : g_follow
      assign gen_sck    = 1'b0;
      assign gen_fs     = 1'b0;
      assign port_drive = 1'b0;
   end

   assign sck_i   = port_drive ? gen_sck : sck_in;
   assign fs_i    = port_drive ? gen_fs  : fs_in;
   assign sck_out = gen_sck;
   assign fs_out  = gen_fs;

   pcm_rx_framer #(.CNT_W(CNT_W)) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .fmt        (fmt),
      .sck_i      (sck_i),
      .fs_i       (fs_i),
      .side_i     ('{c: c_in, u: u_in, v: v_in}),
      .bit_stb    (bit_stb),
      .word_start (word_start),
      .cur_idx    (cur_idx),
      .ended_right(ended_right),
      .armed      (armed),
      .side_cap   (side_cap)
   );

   pcm_rx_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .fmt       (fmt),
      .bit_stb   (bit_stb),
      .word_start(word_start),
      .cur_idx   (cur_idx),
      .sd        (sd_in),
      .word_asm  (word_asm)
   );

   pcm_rx_hold #(.WORD_W(WORD_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (word_start && armed),
      .word_in (word_asm),
      .right_in(ended_right),
      .side_in (side_cap),
      .word_q  (word_out),
      .right_q (word_right),
      .side_q  (side_held),
      .valid_q (word_valid)
   );

   assign side_out = side_held;

   // R8: one-cycle strobe, and a held word that only changes with it
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);
   a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !word_valid |-> ($stable(word_out) && $stable(word_right) && $stable(side_out)));
   // R9: reserved code stays silent
   a_r9_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd3 && $past(mode) == 3'd3) |-> !word_valid);
   // R5: padding below right-justified words
   a_r5_pad16: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && mode == 3'd5) |-> (word_out[WORD_W-17:0] == '0));
   a_r5_pad18: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && mode == 3'd6) |-> (word_out[WORD_W-19:0] == '0));

endmodule

// File: tb/pcm_serial_rx_tb.sv
module pcm_serial_rx_tb;
   localparam int H  = 4;
   localparam int WD = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode = 3'd1;
   logic        sck_in = 1'b0, fs_in = 1'b0, sd_in = 1'b0;
   logic        c_in = 1'b0, u_in = 1'b0, v_in = 1'b0;
   logic        sck_out, fs_out, port_drive, word_right, word_valid;
   logic [23:0] word_out;
   logic [2:0]  side_out;

   int total = 0;
   int bad   = 0;

   logic [23:0] rx_word [64];
   logic        rx_right[64];
   logic [2:0]  rx_side [64];
   int          rx_n = 0;
   int          stab_bad = 0;
   logic [23:0] prev_word = '0;

   logic [23:0] tx_word[8];
   logic [2:0]  tx_side[8];

   pcm_serial_rx u_dut (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .sck_in(sck_in), .fs_in(fs_in), .sd_in(sd_in),
      .c_in(c_in), .u_in(u_in), .v_in(v_in),
      .sck_out(sck_out), .fs_out(fs_out), .port_drive(port_drive),
      .word_out(word_out), .word_right(word_right),
      .side_out(side_out), .word_valid(word_valid)
   );

   always #10 clk = ~clk;

   always @(negedge clk) begin
      if (!rst_n) begin
         prev_word = word_out;
      end else begin
         if (word_valid) begin
            if (rx_n < 64) begin
               rx_word[rx_n]  = word_out;
               rx_right[rx_n] = word_right;
               rx_side[rx_n]  = side_out;
            end
            rx_n++;
         end else if (word_out != prev_word) begin
            stab_bad++;
         end
         prev_word = word_out;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   task automatic do_reset(input logic [2:0] m);
      @(negedge clk);
      rst_n = 1'b0; mode = m;
      sck_in = 1'b0; fs_in = 1'b0; sd_in = 1'b0;
      c_in = 1'b0; u_in = 1'b0; v_in = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic drive_bit(input logic f, input logic d, input logic [2:0] s);
      @(negedge clk);
      sck_in = 1'b0; fs_in = f; sd_in = d;
      c_in = s[2]; u_in = s[1]; v_in = s[0];
      repeat (H) @(negedge clk);
      sck_in = 1'b1;
      repeat (H - 1) @(negedge clk);
   endtask

   task automatic send_slot(input logic [2:0] m, input bit left, input logic [23:0] w,
                            input int n, input int s, input logic [2:0] side, input bit pulse);
      for (int t = 0; t < s; t++) begin
         logic f, d;
         logic [2:0] sv;
         if (m == 3'd2) f = pulse && (t < 2);
         else if (m == 3'd4) f = !left;
         else f = left;
         case (m)
            3'd4:       d = (t >= 1 && t - 1 < n) ? w[n - t] : (t == 0);
            3'd5, 3'd6: d = (t >= s - n) ? w[s - 1 - t] : 1'b1;
            3'd7:       d = (t >= s - n) ? w[t - (s - n)] : 1'b0;
            default:    d = (t < n) ? w[n - 1 - t] : 1'b0;
         endcase
         sv = (t == ((m == 3'd4) ? 1 : 0)) ? side : ~side;
         drive_bit(f, d, sv);
      end
   endtask

   task automatic fill(input logic [23:0] salt);
      for (int k = 0; k < 8; k++) begin
         tx_word[k] = salt ^ (24'h13579B * (k + 1));
         tx_side[k] = 3'(k * 3 + 1);
      end
   endtask

   task automatic run_stream(input logic [2:0] m, input int n, input int s,
                             input int nw, input string req);
      int base;
      logic [23:0] mask, exp;
      do_reset(m);
      base = rx_n;
      send_slot(m, 1'b0, 24'h0, n, s, 3'b000, 1'b0);
      for (int k = 0; k < nw; k++)
         send_slot(m, (k % 2) == 0, tx_word[k], n, s, tx_side[k], 1'b1);
      send_slot(m, (nw % 2) == 0, 24'h0, n, s, 3'b000, 1'b1);
      repeat (5) @(negedge clk);
      if (m == 3'd3) begin
         chk(rx_n == base, "R9", "reserved mode words", rx_n - base, 0);
      end else begin
         chk(rx_n - base == nw, "R8", "word count", rx_n - base, nw);
         mask = (n >= 24) ? 24'hFFFFFF : ((24'h1 << n) - 1);
         for (int k = 0; k < nw && base + k < 64; k++) begin
            exp = (tx_word[k] & mask) << (24 - n);
            chk(rx_word[base + k] == exp, req, "word", rx_word[base + k], exp);
            chk(rx_right[base + k] == (k % 2), req, "channel tag", rx_right[base + k], k % 2);
            chk(rx_side[base + k] == tx_side[k], "R7", "side bits", rx_side[base + k], tx_side[k]);
         end
      end
   endtask

   task automatic test_reset;
      do_reset(3'd1);
      @(negedge clk);
      chk(word_out == 0, "R10", "word_out", word_out, 0);
      chk(word_valid == 0, "R10", "word_valid", word_valid, 0);
      chk(word_right == 0 && side_out == 0, "R10", "tag/side", {word_right, side_out}, 0);
      chk(sck_out == 0 && fs_out == 0, "R10", "generated lines", {sck_out, fs_out}, 0);
      chk(port_drive == 0, "R1", "port_drive in mode 1", port_drive, 0);
   endtask

   task automatic test_master;
      int base, t, nsl, len_last, gap, last_fall;
      logic ps, pf;
      logic [23:0] lw, rw;
      lw = 24'hA5C3E1; rw = 24'h3C5A96;
      do_reset(3'd0);
      c_in = 1'b1; u_in = 1'b1; v_in = 1'b0;
      chk(port_drive == 1, "R1", "port_drive in mode 0", port_drive, 1);
      base = rx_n; t = 0; nsl = 0; len_last = 0; gap = 0; last_fall = 0;
      ps = sck_out; pf = fs_out;
      for (int cyc = 0; cyc < 4000 && rx_n < base + 2; cyc++) begin
         @(negedge clk);
         if (ps && !sck_out) begin
            gap = cyc - last_fall;
            last_fall = cyc;
            if (fs_out != pf) begin
               if (nsl >= 1) len_last = t + 1;
               nsl++;
               t = 0;
            end else begin
               t++;
            end
            sd_in = (t < 24) ? (fs_out ? lw[23 - t] : rw[23 - t]) : 1'b0;
         end
         ps = sck_out; pf = fs_out;
      end
      repeat (2) @(negedge clk);
      chk(gap == 2 * H, "R1", "bit clock period", gap, 2 * H);
      chk(len_last == 32, "R1", "bits per sync half", len_last, 32);
      chk(rx_n - base >= 2, "R1", "words delivered", rx_n - base, 2);
      if (base + 1 < 64) begin
         chk(rx_word[base] == lw && rx_right[base] == 0, "R1", "left word",
             rx_word[base], lw);
         chk(rx_word[base + 1] == rw && rx_right[base + 1] == 1, "R1", "right word",
             rx_word[base + 1], rw);
         chk(rx_side[base] == 3'b110, "R7", "side bits mode 0", rx_side[base], 3'b110);
      end
   endtask

   initial begin
      test_reset();
      fill(24'h5EED01); run_stream(3'd1, 24, 32, 4, "R2");
      fill(24'h0BADF0); run_stream(3'd1, 16, 16, 4, "R2");
      fill(24'h7E1D2C); run_stream(3'd1, 20, 32, 2, "R2");
      fill(24'h4C3B2A); run_stream(3'd2, 24, 32, 4, "R3");
      fill(24'h9182F3); run_stream(3'd4, 20, 32, 4, "R4");
      fill(24'h2468AC); run_stream(3'd5, 16, 32, 4, "R5");
      fill(24'h13F00D); run_stream(3'd6, 18, 32, 4, "R5");
      fill(24'hC0FFEE); run_stream(3'd7, 16, 32, 4, "R6");
      fill(24'hD15EA5); run_stream(3'd7, 24, 24, 2, "R6");
      fill(24'h777777); run_stream(3'd3, 24, 32, 4, "R9");
      test_master();
      chk(stab_bad == 0, "R8", "held outputs changed between strobes", stab_bad, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (WD) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired act=%0d exp=0", WD);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule